// File: doc/BRIEF.md
# Serialized Read Request Processing FSM

This block models the read path of a coherency engine. Read requests arrive as small descriptors and are held in a queue, so that only one cache-line read is in progress at any time. The state machine works only on the oldest queued request. It decides whether that request must first wait for snoops, for the memory acknowledgement of an older dirty writeback, or neither. It raises a read strobe when a memory read is still required, and it waits for the request to be retired before it takes the next one.

A snoop that comes back with dirty data does two things. The dirty line has to be written back, so the machine waits for the memory acknowledgement. The same dirty data also makes the memory read unnecessary, so no read is issued for that request. Data values are not modelled.

Top module: `rdser_engine`

## Requirements
- R1: While reset is asserted and after it is released, `state` is IDLE (encoding 0), the queue is empty, and `issue_rd`, `pop` and `push_rej` are low.
- R2: State encodings are IDLE=0, WAIT_SNOOPS=1, WAIT_WR_ACK=2, ISSUE_RD=3, WAIT_ENTRY_DEALLOC=4. In IDLE with a non-empty queue, a head request that has `req_snp` set moves the machine to WAIT_SNOOPS on the next clock. With an empty queue the machine stays in IDLE.
- R3: In IDLE, a head request without a snoop that needs a read moves to WAIT_WR_ACK if `wb_pend` is high and to ISSUE_RD if `wb_pend` is low. A head request that needs neither a snoop nor a read moves to WAIT_ENTRY_DEALLOC.
- R4: In WAIT_SNOOPS the machine holds until `snp_done`. If `snp_dirty` is set with `snp_done`, the machine moves to WAIT_WR_ACK and the read is cancelled. Otherwise it moves to ISSUE_RD if the request needs a read and to WAIT_ENTRY_DEALLOC if it does not. `snp_dirty` without `snp_done` has no effect.
- R5: In WAIT_WR_ACK the machine holds until `mem_ack`. Then it moves to ISSUE_RD if the read is still needed and to WAIT_ENTRY_DEALLOC if it is not.
- R6: `issue_rd` is high only in the first cycle spent in ISSUE_RD. The machine leaves ISSUE_RD for WAIT_ENTRY_DEALLOC on the clock where `rd_issued` is high.
- R7: `pop` is high exactly in cycles where the state is WAIT_ENTRY_DEALLOC and `done` is high. The machine then returns to IDLE. Requests are processed in arrival order. `done` has no effect in any other state.
- R8: A push (`req_vld`) while the queue holds DEPTH entries raises `push_rej` in that cycle and is not stored. This holds even if a pop happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Push a read request descriptor |
| req_snp | input | 1 | Descriptor: snoop required |
| req_rd | input | 1 | Descriptor: memory read required |
| wb_pend | input | 1 | An older dirty writeback still awaits its memory ack |
| mem_ack | input | 1 | Memory acknowledgement of the pending writeback |
| snp_done | input | 1 | All snoops for the head request have returned |
| snp_dirty | input | 1 | Returned snoop carried dirty data (qualified by snp_done) |
| rd_issued | input | 1 | The memory read has been accepted |
| done | input | 1 | The head request has completed |
| issue_rd | output | 1 | One-cycle strobe requesting the memory read |
| state | output | 3 | Current state encoding |
| pop | output | 1 | The head entry is removed this cycle |
| push_rej | output | 1 | The push this cycle was rejected because the queue is full |

## Verification
The assertions assume that `snp_dirty` matters only together with `snp_done`, and that the event inputs are level samples that may arrive in any state. Handshake inputs that reach the wrong state must be ignored. The checker keeps its own occupancy count from accepted pushes and pops, so it relies on pushes being seen only at the block's edge. The stimulus drives every input freely and at random in every state, including inputs that arrive out of turn. It also uses a stall phase that fills the queue while the head waits on snoops, so the full-queue rejection is reached on purpose.

// File: rtl/rdser_pkg.sv
package rdser_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SNOOP   = 3'd1,
    ST_WBACK   = 3'd2,
    ST_ISSUE   = 3'd3,
    ST_DEALLOC = 3'd4
  } rd_state_e;

  typedef struct packed {
    logic snp_need;
    logic rd_need;
  } rd_desc_t;

  localparam int DESC_W = $bits(rd_desc_t);
endpackage

// File: rtl/rdser_fifo.sv
module rdser_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign wr_ok   = wr_en && !full;
  assign rd_data = mem_q[rptr_q];

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_ok) wptr_q <= ptr_inc(wptr_q);
      if (rd_en) rptr_q <= ptr_inc(rptr_q);
      if (wr_ok && !rd_en)      cnt_q <= cnt_q + 1'b1;
      else if (!wr_ok && rd_en) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_ok && (wptr_q == PW'(g))) mem_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/rdser_fsm.sv
module rdser_fsm
  import rdser_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      head_vld,
  input  rd_desc_t  head,
  input  logic      wb_pend,
  input  logic      mem_ack,
  input  logic      snp_done,
  input  logic      snp_dirty,
  input  logic      rd_issued,
  input  logic      done,
  output rd_state_e state,
  output logic      issue_rd,
  output logic      pop
);
  rd_state_e st_q, st_d;
  logic      rdneed_q, rdneed_d;
  logic      issued_q, issued_d;

  always_comb begin
    st_d     = st_q;
    rdneed_d = rdneed_q;
    case (st_q)
      ST_IDLE: begin
        if (head_vld) begin
          rdneed_d = head.rd_need;
          if (head.snp_need)                st_d = ST_SNOOP;
          else if (head.rd_need && wb_pend) st_d = ST_WBACK;
          else if (head.rd_need)            st_d = ST_ISSUE;
          else                              st_d = ST_DEALLOC;
        end
      end
      ST_SNOOP: begin
        if (snp_done) begin
          if (snp_dirty) begin
            rdneed_d = 1'b0;
            st_d     = ST_WBACK;
          end else begin
            st_d = rdneed_q ? ST_ISSUE : ST_DEALLOC;
          end
        end
      end
      ST_WBACK:   if (mem_ack)   st_d = rdneed_q ? ST_ISSUE : ST_DEALLOC;
      ST_ISSUE:   if (rd_issued) st_d = ST_DEALLOC;
      ST_DEALLOC: if (done)      st_d = ST_IDLE;
      default:                   st_d = ST_IDLE;
    endcase
  end

  assign issued_d = (st_q == ST_ISSUE) && (st_d == ST_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rdneed_q <= 1'b0;
      issued_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      rdneed_q <= rdneed_d;
      issued_q <= issued_d;
    end
  end

  assign state    = st_q;
  assign issue_rd = (st_q == ST_ISSUE) && !issued_q;
  assign pop      = (st_q == ST_DEALLOC) && done;
endmodule

// File: rtl/rdser_engine.sv
module rdser_engine
  import rdser_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_vld,
  input  logic       req_snp,
  input  logic       req_rd,
  input  logic       wb_pend,
  input  logic       mem_ack,
  input  logic       snp_done,
  input  logic       snp_dirty,
  input  logic       rd_issued,
  input  logic       done,
  output logic       issue_rd,
  output logic [2:0] state,
  output logic       pop,
  output logic       push_rej
);
  rd_desc_t          in_desc, head_desc;
  logic [DESC_W-1:0] head_bits;
  logic              q_empty, q_full, pop_w;
  rd_state_e         st_w;

  assign in_desc.snp_need = req_snp;
  assign in_desc.rd_need  = req_rd;
  assign head_desc        = rd_desc_t'(head_bits);

  rdser_fifo #(.DEPTH(DEPTH), .W(DESC_W)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (req_vld),
    .wr_data (in_desc),
    .rd_en   (pop_w),
    .rd_data (head_bits),
    .empty   (q_empty),
    .full    (q_full)
  );

  rdser_fsm fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .head_vld  (!q_empty),
    .head      (head_desc),
    .wb_pend   (wb_pend),
    .mem_ack   (mem_ack),
    .snp_done  (snp_done),
    .snp_dirty (snp_dirty),
    .rd_issued (rd_issued),
    .done      (done),
    .state     (st_w),
    .issue_rd  (issue_rd),
    .pop       (pop_w)
  );

  assign state    = st_w;
  assign pop      = pop_w;
  assign push_rej = req_vld && q_full;
endmodule

// File: rtl/rdser_chk.sv
module rdser_chk #(
  parameter int DEPTH = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_vld,
  input logic       snp_done,
  input logic       snp_dirty,
  input logic       done,
  input logic       issue_rd,
  input logic [2:0] state,
  input logic       pop,
  input logic       push_rej
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] occ_q;
  logic          acc;

  assign acc = req_vld && !push_rej;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else if (acc && !pop) occ_q <= occ_q + 1'b1;
    else if (!acc && pop) occ_q <= occ_q - 1'b1;
  end

  AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && occ_q == '0) |=> state == 3'd0); // R2
  AST_SNOOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1 && !snp_done) |=> state == 3'd1); // R4
  AST_DIRTY_TO_WBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1 && snp_done && snp_dirty) |=> state == 3'd2); // R4
  AST_ISSUE_IN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_rd |-> state == 3'd3); // R6
  AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_rd |=> !issue_rd); // R6
  AST_ISSUE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 3'd3) ##1 (state == 3'd3) |-> issue_rd); // R6
  AST_POP_ONLY_DEALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (state == 3'd4 && done)); // R7
  AST_POP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> state == 3'd0); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_rej |-> occ_q == CW'(DEPTH)); // R8
  AST_FULL_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && occ_q == CW'(DEPTH)) |-> push_rej); // R8
endmodule

bind rdser_engine rdser_chk #(.DEPTH(DEPTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .snp_done  (snp_done),
  .snp_dirty (snp_dirty),
  .done      (done),
  .issue_rd  (issue_rd),
  .state     (state),
  .pop       (pop),
  .push_rej  (push_rej)
);

// File: tb/rdser_engine_tb_top.sv
`timescale 1ns/1ps
module rdser_engine_tb_top;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_vld = 0, req_snp = 0, req_rd = 0, wb_pend = 0, mem_ack = 0;
  logic snp_done = 0, snp_dirty = 0, rd_issued = 0, done = 0;
  logic       issue_rd, pop, push_rej;
  logic [2:0] state;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rdser_engine #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_snp(req_snp),
    .req_rd(req_rd), .wb_pend(wb_pend), .mem_ack(mem_ack),
    .snp_done(snp_done), .snp_dirty(snp_dirty), .rd_issued(rd_issued),
    .done(done), .issue_rd(issue_rd), .state(state), .pop(pop),
    .push_rej(push_rej)
  );

  // reference model state
  logic [1:0] mq[$];
  logic [2:0] m_st;
  logic       m_rd, m_iss;
  string      m_tag;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_issue();
    return (m_st == 3'd3) && !m_iss;
  endfunction

  // compute and commit next model state (called after checks, before posedge)
  logic [2:0] n_st;
  logic       n_rd, n_iss;
  string      n_tag;
  bit         n_pop, n_push;

  task automatic model_next();
    n_st = m_st; n_rd = m_rd; n_tag = m_tag;
    case (m_st)
      3'd0: if (mq.size() != 0) begin
        n_rd = mq[0][0];
        if (mq[0][1]) begin n_st = 3'd1; n_tag = "R2"; end
        else if (mq[0][0] && wb_pend) begin n_st = 3'd2; n_tag = "R3"; end
        else if (mq[0][0]) begin n_st = 3'd3; n_tag = "R3"; end
        else begin n_st = 3'd4; n_tag = "R3"; end
      end else n_tag = "R2";
      3'd1: begin
        n_tag = "R4";
        if (snp_done) begin
          if (snp_dirty) begin n_rd = 1'b0; n_st = 3'd2; end
          else n_st = m_rd ? 3'd3 : 3'd4;
        end
      end
      3'd2: begin n_tag = "R5"; if (mem_ack) n_st = m_rd ? 3'd3 : 3'd4; end
      3'd3: begin n_tag = "R6"; if (rd_issued) n_st = 3'd4; end
      default: begin n_tag = "R7"; if (done) n_st = 3'd0; end
    endcase
    n_iss  = (m_st == 3'd3) && (n_st == 3'd3);
    n_pop  = (m_st == 3'd4) && done;
    n_push = req_vld && (mq.size() < DEPTH);
  endtask

  task automatic model_commit();
    logic [1:0] d;
    d = {req_snp, req_rd};
    if (n_pop) void'(mq.pop_front());
    if (n_push) mq.push_back(d);
    m_st = n_st; m_rd = n_rd; m_iss = n_iss; m_tag = n_tag;
  endtask

  // one cycle: drive at negedge, check before posedge, commit at posedge
  task automatic cycle(input logic v, s, r, wb, ack, sd, sdi, iss, dn);
    @(negedge clk);
    req_vld = v; req_snp = s; req_rd = r; wb_pend = wb; mem_ack = ack;
    snp_done = sd; snp_dirty = sdi; rd_issued = iss; done = dn;
    #1;
    chk(m_tag, "state", state, m_st);
    chk("R6", "issue_rd", issue_rd, exp_issue());
    chk("R7", "pop", pop, (m_st == 3'd4) && done);
    chk("R8", "push_rej", push_rej, req_vld && (mq.size() == DEPTH));
    model_next();
    @(posedge clk);
    model_commit();
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_st = 3'd0; m_rd = 0; m_iss = 0; m_tag = "R1";
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", "state in reset", state, 0);
    chk("R1", "issue_rd in reset", issue_rd, 0);
    chk("R1", "pop in reset", pop, 0);
    chk("R1", "push_rej in reset", push_rej, 0);
    rst_n = 1'b1;
    cycle(0,0,0,0,0,0,0,0,0);
    // R8: fill while head waits on snoops, fifth push rejected
    for (int i = 0; i < DEPTH + 2; i++) cycle(1,1,1,0,0,0,0,0,0);
    // R4: dirty without done ignored, then dirty snoop cancels read
    cycle(0,0,0,0,0,0,1,0,1);
    cycle(0,0,0,0,0,1,1,0,0);
    cycle(0,0,0,0,0,0,0,1,1);   // R5/R7: stray done and issue ignored in WAIT_WR_ACK
    cycle(0,0,0,0,1,0,0,0,0);   // ack -> dealloc (read cancelled)
    cycle(0,0,0,0,0,0,0,0,1);   // R7 pop
    // R3/R6: drain with clean snoops, read issued later than strobe
    for (int i = 0; i < 40; i++) cycle(0,0,0,1,(i%3)==0,(i%4)==1,0,(i%5)==2,(i%2)==1);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      cycle(($urandom%100) < 35, $urandom%2, $urandom%2, $urandom%2,
            ($urandom%100) < 30, ($urandom%100) < 30, $urandom%2,
            ($urandom%100) < 35, ($urandom%100) < 35);
    end
    // R8: reject when full with simultaneous pop
    for (int i = 0; i < 40; i++) cycle(1,0,0,0,0,0,0,0,(i%6)==5);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule